// File: doc/BRIEF.md
# Load/Store Issue Iteration Sequencer

This block sits between instruction decode and the execute pipeline. It accepts one decoded memory-transfer instruction at a time over a valid/ready handshake and expands it into one or two issue iterations. For every iteration it reports which architectural registers have to be read, and the execute stage (E1, E2 or E3) at which each is needed. It also reports which registers that iteration produces, with their stages, including the updated base register when writeback is requested.

The iteration count depends only on the addressing form. Double-word transfers and scaled register offsets whose shift is not the fast amount take two iterations. Everything else takes one. Access width below double-word and data type have no inputs here, because they do not change the timing. An external scoreboard marks registers whose values are not yet available. An iteration is held back while any register it needs at E1 is marked, and decode sees `in_ready` low until the final iteration of the held instruction issues.

Top module: `lsu_issue_seq`

## Requirements
- R1: An immediate-offset (`in_mode`=0) or register-offset (`in_mode`=1) transfer with `in_dbl`=0 issues in exactly one iteration (`iss_iter`=0, `iss_last`=1). A scaled-offset transfer (`in_mode`=2) with `in_shift`=2 and `in_dbl`=0 also issues in exactly one iteration.
- R2: A transfer with `in_dbl`=1 issues two iterations on consecutive cycles (`iss_iter` 0 then 1, `iss_last` 0 then 1). A double load reports the Rd+1 result at E3 in the second iteration only. A double store reads both Rd and Rd+1 at E3 in the first iteration and reads nothing in the second.
- R3: A scaled-offset transfer with `in_shift`≠2 issues two iterations. Its base writeback is reported in the second iteration, not the first.
- R4: The base register is read at E1 in the first iteration. The offset register is read at E1 in the first iteration only for `in_mode` 1, 2 or 3, and never for `in_mode`=0. No register is read in a second iteration.
- R5: A load reports its Rd result at E3 in the first iteration. A store reports no Rd result. When enabled and not deferred by R3, the base writeback is reported at E2 in the first iteration.
- R6: With `in_wb`=0 no base result is reported in any iteration.
- R7: An instruction is accepted only on a cycle with `in_valid`=1 and `in_ready`=1, and its first iteration is presented on the following cycle. `in_ready` is low (and `busy` high) while a held instruction has not yet issued its final iteration. A new instruction can be accepted in the same cycle that the final iteration issues.
- R8: No iteration issues while `src_pend` is set for a register that the iteration reads at E1. A pending store-data register, needed at E3, does not hold issue back.
- R9: Rd+1 is computed modulo the register count, so Rd = NREG-1 pairs with register 0.
- R10: After reset `iss_valid`=0, `in_ready`=1 and `busy`=0.

Stage codes on every `*_stg` output: 0 = none, 1 = E1, 2 = E2, 3 = E3. A slot's `*_en` and `*_stg` are only non-zero while `iss_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decode offers an instruction |
| in_ready | output | 1 | Sequencer can take an instruction this cycle |
| in_store | input | 1 | 1 = store, 0 = load |
| in_mode | input | 2 | 0 immediate, 1 register, 2 scaled register, 3 treated as register |
| in_shift | input | SHW | Left-shift amount of a scaled offset |
| in_dbl | input | 1 | Double-word transfer (Rd and Rd+1) |
| in_wb | input | 1 | Base writeback requested |
| in_rn | input | IDXW | Base register index |
| in_rm | input | IDXW | Offset register index |
| in_rd | input | IDXW | Data register index |
| src_pend | input | NREG | Scoreboard: bit i set means register i is not yet available |
| busy | output | 1 | Held instruction still has an iteration to issue |
| iss_valid | output | 1 | An iteration issues this cycle |
| iss_iter | output | 1 | 0 first iteration, 1 second |
| iss_last | output | 1 | This is the final iteration |
| rd_base_en | output | 1 | Base register read |
| rd_base_idx | output | IDXW | Base read index |
| rd_base_stg | output | 2 | Base read stage |
| rd_off_en | output | 1 | Offset register read |
| rd_off_idx | output | IDXW | Offset read index |
| rd_off_stg | output | 2 | Offset read stage |
| rd_data_en | output | 1 | Store data Rd read |
| rd_data_idx | output | IDXW | Store data read index |
| rd_data_stg | output | 2 | Store data read stage |
| rd_hi_en | output | 1 | Store data Rd+1 read |
| rd_hi_idx | output | IDXW | Rd+1 read index |
| rd_hi_stg | output | 2 | Rd+1 read stage |
| wr_data_en | output | 1 | Load result Rd produced |
| wr_data_idx | output | IDXW | Rd result index |
| wr_data_stg | output | 2 | Rd result stage |
| wr_hi_en | output | 1 | Load result Rd+1 produced |
| wr_hi_idx | output | IDXW | Rd+1 result index |
| wr_hi_stg | output | 2 | Rd+1 result stage |
| wr_base_en | output | 1 | Updated base produced |
| wr_base_idx | output | IDXW | Base result index |
| wr_base_stg | output | 2 | Base result stage |

## Verification
The hardest situation to reach is the overlap at the handshake edge: an instruction offered while another is mid-sequence must wait through the first iteration, and it must be taken in the very cycle the final iteration leaves. The bench holds `in_valid` high across a two-iteration scaled load so that `in_ready` is sampled low in the first iteration and high in the second, then confirms that the waiting instruction appears on the next cycle. A scoreboard stall is produced by marking the offset register pending before the instruction arrives and releasing it mid-cycle. A pending store-data register is used to show that an E3 operand never stalls.

// File: rtl/lsu_seq_pkg.sv
// Shared constants for the load/store issue sequencer.
// Assumes stage and mode codes are 2 bits wide; slot numbering is fixed here.
package lsu_seq_pkg;

    // Pipeline stage codes reported on every *_stg output
    localparam logic [1:0] STG_NONE = 2'd0;
    localparam logic [1:0] STG_E1   = 2'd1;
    localparam logic [1:0] STG_E2   = 2'd2;
    localparam logic [1:0] STG_E3   = 2'd3;

    // Addressing forms
    localparam logic [1:0] AM_IMM    = 2'd0;
    localparam logic [1:0] AM_REG    = 2'd1;
    localparam logic [1:0] AM_SCALED = 2'd2;

    // Read slots
    localparam int NRD     = 4;
    localparam int RS_BASE = 0;
    localparam int RS_OFF  = 1;
    localparam int RS_DATA = 2;
    localparam int RS_HI   = 3;

    // Write slots
    localparam int NWR     = 3;
    localparam int WS_DATA = 0;
    localparam int WS_HI   = 1;
    localparam int WS_BASE = 2;

    // Stage at which a read slot needs its operand
    function automatic logic [1:0] rd_stage_of(input int slot);
        return (slot == RS_BASE || slot == RS_OFF) ? STG_E1 : STG_E3;
    endfunction

    // Stage at which a write slot produces its result
    function automatic logic [1:0] wr_stage_of(input int slot);
        return (slot == WS_BASE) ? STG_E2 : STG_E3;
    endfunction

endpackage

// File: rtl/lsu_seq_ctrl.sv
// Holding register and iteration counter for the sequencer.
// Assumes the iteration decode supplies 'last' and the hazard check supplies
// 'stall' combinationally from the held fields; both depend only on registers
// and src_pend, so no loop passes through in_valid.
module lsu_seq_ctrl #(
    parameter int SHW  = 5,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_store,
    input  logic [1:0]      in_mode,
    input  logic [SHW-1:0]  in_shift,
    input  logic            in_dbl,
    input  logic            in_wb,
    input  logic [IDXW-1:0] in_rn,
    input  logic [IDXW-1:0] in_rm,
    input  logic [IDXW-1:0] in_rd,
    input  logic            stall,
    input  logic            last,
    output logic            fire,
    output logic            iter,
    output logic            h_store,
    output logic [1:0]      h_mode,
    output logic [SHW-1:0]  h_shift,
    output logic            h_dbl,
    output logic            h_wb,
    output logic [IDXW-1:0] h_rn,
    output logic [IDXW-1:0] h_rm,
    output logic [IDXW-1:0] h_rd
);

    logic held;
    logic accept;

    // Issue and handshake qualifiers
    always_comb begin
        fire     = held && !stall;
        in_ready = !held || (fire && last);
        accept   = in_valid && in_ready;
    end

    // Occupancy flag and iteration counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            iter <= 1'b0;
        end else if (accept) begin
            held <= 1'b1;
            iter <= 1'b0;
        end else if (fire) begin
            if (last) begin
                held <= 1'b0;
                iter <= 1'b0;
            end else begin
                iter <= 1'b1;
            end
        end
    end

    // Instruction fields captured on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_store <= 1'b0;
            h_mode  <= AM_IMM_C;
            h_shift <= '0;
            h_dbl   <= 1'b0;
            h_wb    <= 1'b0;
            h_rn    <= '0;
            h_rm    <= '0;
            h_rd    <= '0;
        end else if (accept) begin
            h_store <= in_store;
            h_mode  <= in_mode;
            h_shift <= in_shift;
            h_dbl   <= in_dbl;
            h_wb    <= in_wb;
            h_rn    <= in_rn;
            h_rm    <= in_rm;
            h_rd    <= in_rd;
        end
    end

    localparam logic [1:0] AM_IMM_C = lsu_seq_pkg::AM_IMM;

endmodule

// File: rtl/lsu_seq_decode.sv
// Per-iteration slot decode: from the held instruction and the iteration
// number, works out the iteration count and every read and write slot with
// its index and stage. Purely combinational.
// Assumes a second iteration reads nothing; Rd+1 wraps modulo NREG.
module lsu_seq_decode
    import lsu_seq_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int SHW       = 5,
    parameter int SCALE_ONE = 2,
    parameter int IDXW      = 4
) (
    input  logic                      is_store,
    input  logic [1:0]                mode,
    input  logic [SHW-1:0]            shift,
    input  logic                      dbl,
    input  logic                      wb,
    input  logic [IDXW-1:0]           rn,
    input  logic [IDXW-1:0]           rm,
    input  logic [IDXW-1:0]           rd,
    input  logic                      iter,
    output logic                      last,
    output logic [NRD-1:0]            rd_en,
    output logic [NRD-1:0][IDXW-1:0]  rd_idx,
    output logic [NRD-1:0][1:0]       rd_stg,
    output logic [NWR-1:0]            wr_en,
    output logic [NWR-1:0][IDXW-1:0]  wr_idx,
    output logic [NWR-1:0][1:0]       wr_stg
);

    localparam logic [IDXW-1:0] TOP_IDX  = IDXW'(NREG - 1);
    localparam logic [SHW-1:0]  FAST_SHL = SHW'(SCALE_ONE);

    logic first;
    logic slow_scale;
    logic two_iter;
    logic [IDXW-1:0] rd_hi;

    // Iteration count and pair index
    always_comb begin
        first      = !iter;
        slow_scale = (mode == AM_SCALED) && (shift != FAST_SHL);
        two_iter   = dbl || slow_scale;
        last       = !two_iter || iter;
        rd_hi      = (rd == TOP_IDX) ? '0 : rd + 1'b1;
    end

    // Slot enables and indices
    always_comb begin
        rd_en[RS_BASE]  = first;
        rd_idx[RS_BASE] = rn;
        rd_en[RS_OFF]   = first && (mode != AM_IMM);
        rd_idx[RS_OFF]  = rm;
        rd_en[RS_DATA]  = first && is_store;
        rd_idx[RS_DATA] = rd;
        rd_en[RS_HI]    = first && is_store && dbl;
        rd_idx[RS_HI]   = rd_hi;

        wr_en[WS_DATA]  = first && !is_store;
        wr_idx[WS_DATA] = rd;
        wr_en[WS_HI]    = !first && !is_store && dbl;
        wr_idx[WS_HI]   = rd_hi;
        wr_en[WS_BASE]  = wb && (slow_scale ? !first : first);
        wr_idx[WS_BASE] = rn;
    end

    // Stage codes attached to each enabled slot
    for (genvar i = 0; i < NRD; i++) begin : g_rd_stage
        assign rd_stg[i] = rd_en[i] ? rd_stage_of(i) : STG_NONE;
    end
    for (genvar j = 0; j < NWR; j++) begin : g_wr_stage
        assign wr_stg[j] = wr_en[j] ? wr_stage_of(j) : STG_NONE;
    end

endmodule

// File: rtl/lsu_seq_hazard.sv
// Scoreboard check: an iteration stalls when any read slot needed at E1 names
// a register whose pending bit is set. Operands needed later do not stall.
// Assumes slot stage codes come from lsu_seq_decode.
module lsu_seq_hazard
    import lsu_seq_pkg::*;
#(
    parameter int NREG = 16,
    parameter int IDXW = 4
) (
    input  logic [NRD-1:0]           rd_en,
    input  logic [NRD-1:0][IDXW-1:0] rd_idx,
    input  logic [NRD-1:0][1:0]      rd_stg,
    input  logic [NREG-1:0]          src_pend,
    output logic                     stall
);

    logic [NRD-1:0] hit;

    // One early-operand hazard term per read slot
    for (genvar i = 0; i < NRD; i++) begin : g_hit
        assign hit[i] = rd_en[i] && (rd_stg[i] == STG_E1) && src_pend[rd_idx[i]];
    end

    // Any hit holds the iteration
    assign stall = |hit;

endmodule

// File: rtl/lsu_issue_seq.sv
// Top of the load/store issue sequencer: accepts one decoded transfer per
// handshake and emits one or two issue iterations with register read and
// result slots and their pipeline stages.
// Assumes src_pend is valid every cycle; slot outputs are zero unless issuing.
module lsu_issue_seq
    import lsu_seq_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int SHW       = 5,
    parameter int SCALE_ONE = 2,
    localparam int IDXW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_store,
    input  logic [1:0]      in_mode,
    input  logic [SHW-1:0]  in_shift,
    input  logic            in_dbl,
    input  logic            in_wb,
    input  logic [IDXW-1:0] in_rn,
    input  logic [IDXW-1:0] in_rm,
    input  logic [IDXW-1:0] in_rd,
    input  logic [NREG-1:0] src_pend,
    output logic            busy,
    output logic            iss_valid,
    output logic            iss_iter,
    output logic            iss_last,
    output logic            rd_base_en,
    output logic [IDXW-1:0] rd_base_idx,
    output logic [1:0]      rd_base_stg,
    output logic            rd_off_en,
    output logic [IDXW-1:0] rd_off_idx,
    output logic [1:0]      rd_off_stg,
    output logic            rd_data_en,
    output logic [IDXW-1:0] rd_data_idx,
    output logic [1:0]      rd_data_stg,
    output logic            rd_hi_en,
    output logic [IDXW-1:0] rd_hi_idx,
    output logic [1:0]      rd_hi_stg,
    output logic            wr_data_en,
    output logic [IDXW-1:0] wr_data_idx,
    output logic [1:0]      wr_data_stg,
    output logic            wr_hi_en,
    output logic [IDXW-1:0] wr_hi_idx,
    output logic [1:0]      wr_hi_stg,
    output logic            wr_base_en,
    output logic [IDXW-1:0] wr_base_idx,
    output logic [1:0]      wr_base_stg
);

    logic                     fire, iter, last, stall;
    logic                     h_store, h_dbl, h_wb;
    logic [1:0]               h_mode;
    logic [SHW-1:0]           h_shift;
    logic [IDXW-1:0]          h_rn, h_rm, h_rd;
    logic [NRD-1:0]           rd_en;
    logic [NRD-1:0][IDXW-1:0] rd_idx;
    logic [NRD-1:0][1:0]      rd_stg;
    logic [NWR-1:0]           wr_en;
    logic [NWR-1:0][IDXW-1:0] wr_idx;
    logic [NWR-1:0][1:0]      wr_stg;
    logic [NRD-1:0]           rd_go;
    logic [NWR-1:0]           wr_go;

    lsu_seq_ctrl #(.SHW(SHW), .IDXW(IDXW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_store(in_store), .in_mode(in_mode), .in_shift(in_shift),
        .in_dbl(in_dbl), .in_wb(in_wb), .in_rn(in_rn), .in_rm(in_rm),
        .in_rd(in_rd), .stall(stall), .last(last), .fire(fire), .iter(iter),
        .h_store(h_store), .h_mode(h_mode), .h_shift(h_shift), .h_dbl(h_dbl),
        .h_wb(h_wb), .h_rn(h_rn), .h_rm(h_rm), .h_rd(h_rd)
    );

    lsu_seq_decode #(.NREG(NREG), .SHW(SHW), .SCALE_ONE(SCALE_ONE), .IDXW(IDXW)) u_dec (
        .is_store(h_store), .mode(h_mode), .shift(h_shift), .dbl(h_dbl),
        .wb(h_wb), .rn(h_rn), .rm(h_rm), .rd(h_rd), .iter(iter), .last(last),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_stg(rd_stg),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_stg(wr_stg)
    );

    lsu_seq_hazard #(.NREG(NREG), .IDXW(IDXW)) u_haz (
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_stg(rd_stg),
        .src_pend(src_pend), .stall(stall)
    );

    // Issue status, qualified by the issue strobe
    always_comb begin
        iss_valid = fire;
        iss_iter  = fire && iter;
        iss_last  = fire && last;
        busy      = !in_ready;
        rd_go     = rd_en & {NRD{fire}};
        wr_go     = wr_en & {NWR{fire}};
    end

    // Read slot outputs
    always_comb begin
        rd_base_en  = rd_go[RS_BASE];
        rd_base_idx = rd_idx[RS_BASE];
        rd_base_stg = rd_go[RS_BASE] ? rd_stg[RS_BASE] : STG_NONE;
        rd_off_en   = rd_go[RS_OFF];
        rd_off_idx  = rd_idx[RS_OFF];
        rd_off_stg  = rd_go[RS_OFF] ? rd_stg[RS_OFF] : STG_NONE;
        rd_data_en  = rd_go[RS_DATA];
        rd_data_idx = rd_idx[RS_DATA];
        rd_data_stg = rd_go[RS_DATA] ? rd_stg[RS_DATA] : STG_NONE;
        rd_hi_en    = rd_go[RS_HI];
        rd_hi_idx   = rd_idx[RS_HI];
        rd_hi_stg   = rd_go[RS_HI] ? rd_stg[RS_HI] : STG_NONE;
    end

    // Write slot outputs
    always_comb begin
        wr_data_en  = wr_go[WS_DATA];
        wr_data_idx = wr_idx[WS_DATA];
        wr_data_stg = wr_go[WS_DATA] ? wr_stg[WS_DATA] : STG_NONE;
        wr_hi_en    = wr_go[WS_HI];
        wr_hi_idx   = wr_idx[WS_HI];
        wr_hi_stg   = wr_go[WS_HI] ? wr_stg[WS_HI] : STG_NONE;
        wr_base_en  = wr_go[WS_BASE];
        wr_base_idx = wr_idx[WS_BASE];
        wr_base_stg = wr_go[WS_BASE] ? wr_stg[WS_BASE] : STG_NONE;
    end

endmodule

// File: rtl/lsu_issue_seq_chk.sv
// Port-level protocol checker for lsu_issue_seq, attached by bind below.
// Assumes the stage code convention of lsu_seq_pkg.
module lsu_issue_seq_chk #(
    parameter int NREG = 16,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            busy,
    input logic [NREG-1:0] src_pend,
    input logic            iss_valid,
    input logic            iss_iter,
    input logic            iss_last,
    input logic            rd_base_en,
    input logic [IDXW-1:0] rd_base_idx,
    input logic            rd_off_en,
    input logic [IDXW-1:0] rd_off_idx,
    input logic [1:0]      rd_data_stg,
    input logic            wr_hi_en,
    input logic [1:0]      wr_base_stg,
    input logic            wr_base_en
);

    // R10: reset leaves no iteration issuing
    assert_reset_idle_R10: assert property (@(posedge clk) !rst_n |=> !iss_valid);

    // R7: decode is held off while a non-final iteration issues
    assert_ready_low_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_last) |-> (!in_ready && busy));

    // R7: the final iteration frees the handshake
    assert_ready_at_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_last) |-> in_ready);

    // R2: a second iteration follows a non-final one on the next cycle
    assert_second_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_last) |=> (iss_valid && iss_iter && iss_last));

    // R8: an E1 operand is never issued while pending
    assert_base_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_base_en |-> !src_pend[rd_base_idx]);
    assert_off_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_off_en |-> !src_pend[rd_off_idx]);

    // R4: no reads in a second iteration
    assert_no_late_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_iter) |-> (!rd_base_en && !rd_off_en && rd_data_stg == 2'd0));

    // R2: Rd+1 load result only in the second iteration
    assert_hi_late_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_en |-> iss_iter);

    // R5: base writeback always at E2
    assert_base_e2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_base_en |-> (wr_base_stg == 2'd2));

    // R7: nothing accepted means nothing issues next cycle from an idle block
    assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid && !iss_valid) |=> !iss_valid);

endmodule

bind lsu_issue_seq lsu_issue_seq_chk #(.NREG(NREG), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .busy(busy), .src_pend(src_pend), .iss_valid(iss_valid),
    .iss_iter(iss_iter), .iss_last(iss_last), .rd_base_en(rd_base_en),
    .rd_base_idx(rd_base_idx), .rd_off_en(rd_off_en), .rd_off_idx(rd_off_idx),
    .rd_data_stg(rd_data_stg), .wr_hi_en(wr_hi_en), .wr_base_stg(wr_base_stg),
    .wr_base_en(wr_base_en)
);

// File: tb/lsu_issue_seq_bench.sv
// Directed bench for lsu_issue_seq: one task per scenario, each checking
// its own results at the falling clock edge.
module lsu_issue_seq_bench;

    localparam int NREG = 16;
    localparam int SHW  = 5;
    localparam int IDXW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_store = 1'b0, in_dbl = 1'b0, in_wb = 1'b0;
    logic [1:0] in_mode = 2'd0;
    logic [SHW-1:0] in_shift = '0;
    logic [IDXW-1:0] in_rn = '0, in_rm = '0, in_rd = '0;
    logic [NREG-1:0] src_pend = '0;
    logic in_ready, busy, iss_valid, iss_iter, iss_last;
    logic rd_base_en, rd_off_en, rd_data_en, rd_hi_en, wr_data_en, wr_hi_en, wr_base_en;
    logic [IDXW-1:0] rd_base_idx, rd_off_idx, rd_data_idx, rd_hi_idx;
    logic [IDXW-1:0] wr_data_idx, wr_hi_idx, wr_base_idx;
    logic [1:0] rd_base_stg, rd_off_stg, rd_data_stg, rd_hi_stg;
    logic [1:0] wr_data_stg, wr_hi_stg, wr_base_stg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsu_issue_seq #(.NREG(NREG), .SHW(SHW), .SCALE_ONE(2)) u_lsu_issue_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_store(in_store), .in_mode(in_mode), .in_shift(in_shift),
        .in_dbl(in_dbl), .in_wb(in_wb), .in_rn(in_rn), .in_rm(in_rm),
        .in_rd(in_rd), .src_pend(src_pend), .busy(busy), .iss_valid(iss_valid),
        .iss_iter(iss_iter), .iss_last(iss_last),
        .rd_base_en(rd_base_en), .rd_base_idx(rd_base_idx), .rd_base_stg(rd_base_stg),
        .rd_off_en(rd_off_en), .rd_off_idx(rd_off_idx), .rd_off_stg(rd_off_stg),
        .rd_data_en(rd_data_en), .rd_data_idx(rd_data_idx), .rd_data_stg(rd_data_stg),
        .rd_hi_en(rd_hi_en), .rd_hi_idx(rd_hi_idx), .rd_hi_stg(rd_hi_stg),
        .wr_data_en(wr_data_en), .wr_data_idx(wr_data_idx), .wr_data_stg(wr_data_stg),
        .wr_hi_en(wr_hi_en), .wr_hi_idx(wr_hi_idx), .wr_hi_stg(wr_hi_stg),
        .wr_base_en(wr_base_en), .wr_base_idx(wr_base_idx), .wr_base_stg(wr_base_stg)
    );

    task automatic check_val(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One slot packed as {en, idx masked by en, stage}
    function automatic logic [6:0] slot(input bit en, input int idx, input logic [1:0] stg);
        return {en, en ? 4'(idx) : 4'd0, en ? stg : 2'd0};
    endfunction

    // Whole-iteration comparison; expected stages: reads of base/offset at E1,
    // data reads at E3, data results at E3, base result at E2
    task automatic expect_iter(input string req, input bit v, input bit lst, input bit it,
                               input bit bn, input int bi, input bit on_, input int oi,
                               input bit dn, input int di, input bit hn, input int hi,
                               input bit wdn, input int wdi, input bit whn, input int whi,
                               input bit wbn, input int wbi);
        logic [51:0] act, exp;
        act = {iss_valid, iss_last, iss_iter,
               slot(rd_base_en, int'(rd_base_idx), rd_base_stg),
               slot(rd_off_en, int'(rd_off_idx), rd_off_stg),
               slot(rd_data_en, int'(rd_data_idx), rd_data_stg),
               slot(rd_hi_en, int'(rd_hi_idx), rd_hi_stg),
               slot(wr_data_en, int'(wr_data_idx), wr_data_stg),
               slot(wr_hi_en, int'(wr_hi_idx), wr_hi_stg),
               slot(wr_base_en, int'(wr_base_idx), wr_base_stg)};
        exp = {v, lst, it,
               slot(bn, bi, 2'd1), slot(on_, oi, 2'd1), slot(dn, di, 2'd3),
               slot(hn, hi, 2'd3), slot(wdn, wdi, 2'd3), slot(whn, whi, 2'd3),
               slot(wbn, wbi, 2'd2)};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s iteration: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input bit st, input int md, input int sh, input bit db, input bit wb,
                         input int rn, input int rm, input int rd);
        in_valid = 1'b1; in_store = st; in_mode = 2'(md); in_shift = SHW'(sh);
        in_dbl = db; in_wb = wb; in_rn = 4'(rn); in_rm = 4'(rm); in_rd = 4'(rd);
    endtask

    // Offer at a falling edge, accept on the rising edge, first iteration
    // visible at the next falling edge
    task automatic send(input bit st, input int md, input int sh, input bit db, input bit wb,
                        input int rn, input int rm, input int rd);
        drive(st, md, sh, db, wb, rn, rm, rd);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        check_val("R10", "in_ready", int'(in_ready), 1);
        check_val("R10", "iss_valid", int'(iss_valid), 0);
        check_val("R10", "busy", int'(busy), 0);
    endtask

    task automatic t_load_imm();
        send(0, 0, 0, 0, 1, 3, 6, 5);
        // R1 R5: one iteration, Rd at E3, base at E2, no offset read (R4)
        expect_iter("R1", 1,1,0, 1,3, 0,0, 0,0, 0,0, 1,5, 0,0, 1,3);
        step();
        check_val("R1", "iss_valid after single", int'(iss_valid), 0);
        check_val("R1", "in_ready after single", int'(in_ready), 1);
    endtask

    task automatic t_store_reg();
        send(1, 1, 0, 0, 0, 2, 7, 9);
        // R4 R6: base and offset at E1, data at E3, no results
        expect_iter("R6", 1,1,0, 1,2, 1,7, 1,9, 0,0, 0,0, 0,0, 0,0);
        step();
    endtask

    task automatic t_scaled_fast();
        send(0, 2, 2, 0, 1, 4, 1, 8);
        expect_iter("R1", 1,1,0, 1,4, 1,1, 0,0, 0,0, 1,8, 0,0, 1,4);
        step();
    endtask

    task automatic t_scaled_slow_load();
        send(0, 2, 3, 0, 1, 4, 1, 8);
        expect_iter("R3", 1,0,0, 1,4, 1,1, 0,0, 0,0, 1,8, 0,0, 0,0);
        check_val("R7", "in_ready mid", int'(in_ready), 0);
        check_val("R7", "busy mid", int'(busy), 1);
        step();
        expect_iter("R3", 1,1,1, 0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 1,4);
        step();
        check_val("R3", "iss_valid after pair", int'(iss_valid), 0);
    endtask

    task automatic t_scaled_slow_store();
        send(1, 2, 0, 0, 1, 10, 11, 12);
        expect_iter("R3", 1,0,0, 1,10, 1,11, 1,12, 0,0, 0,0, 0,0, 0,0);
        step();
        expect_iter("R3", 1,1,1, 0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 1,10);
        step();
    endtask

    task automatic t_dbl_load_wrap();
        send(0, 0, 0, 1, 1, 1, 0, 15);
        expect_iter("R2", 1,0,0, 1,1, 0,0, 0,0, 0,0, 1,15, 0,0, 1,1);
        step();
        // R9: Rd+1 of the top register is register 0
        expect_iter("R9", 1,1,1, 0,0, 0,0, 0,0, 0,0, 0,0, 1,0, 0,0);
        step();
    endtask

    task automatic t_dbl_store();
        send(1, 1, 0, 1, 0, 6, 7, 4);
        expect_iter("R2", 1,0,0, 1,6, 1,7, 1,4, 1,5, 0,0, 0,0, 0,0);
        step();
        expect_iter("R2", 1,1,1, 0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 0,0);
        step();
    endtask

    task automatic t_stall();
        src_pend = 16'h0080;
        send(0, 1, 0, 0, 0, 6, 7, 3);
        expect_iter("R8", 0,0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 0,0);
        check_val("R8", "in_ready stalled", int'(in_ready), 0);
        step();
        expect_iter("R8", 0,0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 0,0);
        src_pend = '0;
        #1;
        expect_iter("R8", 1,1,0, 1,6, 1,7, 0,0, 0,0, 1,3, 0,0, 0,0);
        step();
        // store data pending at E3 does not hold issue
        src_pend = 16'h0200;
        send(1, 0, 0, 0, 0, 2, 0, 9);
        expect_iter("R8", 1,1,0, 1,2, 0,0, 1,9, 0,0, 0,0, 0,0, 0,0);
        step();
        src_pend = '0;
    endtask

    task automatic t_no_accept();
        in_valid = 1'b0; in_store = 1'b0; in_mode = 2'd0; in_rn = 4'd5; in_rd = 4'd6;
        step();
        step();
        check_val("R7", "no issue without valid", int'(iss_valid), 0);
    endtask

    task automatic t_overlap();
        // held instruction waits through the first iteration
        send(0, 2, 1, 0, 0, 4, 1, 8);
        drive(1, 0, 0, 0, 0, 3, 0, 4);
        #1;
        check_val("R7", "in_ready first of two", int'(in_ready), 0);
        step();
        check_val("R7", "in_ready final", int'(in_ready), 1);
        check_val("R7", "second iteration", int'(iss_iter), 1);
        step();
        in_valid = 1'b0;
        #1;
        expect_iter("R7", 1,1,0, 1,3, 0,0, 1,4, 0,0, 0,0, 0,0, 0,0);
        // back-to-back: accept while a single iteration issues
        drive(0, 1, 0, 0, 1, 11, 12, 13);
        #1;
        check_val("R7", "in_ready during last", int'(in_ready), 1);
        step();
        in_valid = 1'b0;
        #1;
        expect_iter("R7", 1,1,0, 1,11, 1,12, 0,0, 0,0, 1,13, 0,0, 1,11);
        step();
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_load_imm();
        t_store_reg();
        t_scaled_fast();
        t_scaled_slow_load();
        t_scaled_slow_store();
        t_dbl_load_wrap();
        t_dbl_store();
        t_stall();
        t_no_accept();
        t_overlap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule